// File: doc/BRIEF.md
# Bus Operand Aligner and Port Sizer

This block sits between a 32-bit internal operand path and an external data bus whose memory ports may be 8, 16 or 32 bits wide. A request carries an address, an operand size, a direction, right-justified write data and a flag that says whether the internal memory controller owns the target. The block rejects requests whose address does not suit the operand size. It places the operand bytes on big-endian byte lanes, with lane 0 as the most significant byte. It then runs one or more bus cycles until every operand byte has moved.

The first bus cycle always assumes a 32-bit port. The memory side reports the width of the port it really has at the moment it acknowledges the cycle. When that port is narrower than the bytes still pending, the block issues another cycle at the next address, with the pending bytes steered onto the low lanes. On reads the bytes returned in each cycle are merged into an operand image. The result is handed back right-justified, together with a one-cycle done pulse after the final acknowledge.

Top module: `bus_operand_aligner`

## Requirements
- R1: Size codes are 0 byte, 1 half-word, 2 word and 3 burst. A byte is legal at any address. A half-word needs address bit 0 clear. A word or burst needs address bits 1:0 clear. An idle block given an illegal request pulses `misalign` high for exactly one cycle, one cycle after the request, and starts no bus cycle.
- R2: A burst request is carried as a word-sized first beat, with `bus_burst` high for the duration of its cycles.
- R3: One cycle after a legal request is taken, `bus_req` and `busy` are high. In that cycle `bus_addr` equals the request address and `bus_len` equals the operand byte count (1, 2 or 4), whatever the port width turns out to be.
- R4: Lane l of `bus_wdata` is bits [31-8l:24-8l] and carries the byte whose address offset within the word is l. A write operand is taken right-justified from `req_wdata`: a byte in [7:0], and a half-word in [15:0] with [15:8] going to the lower address.
- R5: During a write cycle, lane 0 always carries the first pending byte. Lanes 0 and 1 also carry copies of the pending bytes at offsets 2 and 3 when those offsets lie in the pending range. This lets narrow ports see the data on their fixed lanes.
- R6: `bus_port` is sampled with `bus_ack`: 00 and 11 mean 32 bits, 01 means 8 bits and 10 means 16 bits. A 32-bit port takes all pending bytes. A 16-bit port takes two bytes from an even offset and one from an odd offset. An 8-bit port takes one byte. If bytes remain, the next cycle follows directly, with `bus_addr` advanced by the bytes taken and `bus_len` reduced by the same amount.
- R7: When `req_ctrl_int` was low at the request, `bus_port` is ignored and every transfer completes on its first acknowledge.
- R8: On reads, the byte at offset p is taken from lane p for a 32-bit port, from lane (p mod 2) for a 16-bit port, and from lane 0 for an 8-bit port. `rd_data` is right-justified, with the unused upper bytes zero.
- R9: `done` is high for exactly one cycle, the cycle after the final acknowledge. In that cycle `busy` and `bus_req` are low and `rd_data` is valid.
- R10: A request presented while `busy` is high is ignored: the running cycle keeps its address and length, and no transfer follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_addr | input | 32 | Byte address of the operand |
| req_size | input | 2 | Operand size code |
| req_we | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 32 | Right-justified write operand |
| req_ctrl_int | input | 1 | Target is handled by the internal memory controller |
| busy | output | 1 | Transfer in progress |
| misalign | output | 1 | Illegal alignment pulse |
| done | output | 1 | Transfer finished pulse |
| rd_data | output | 32 | Right-justified read operand |
| bus_req | output | 1 | Bus cycle active |
| bus_we | output | 1 | Bus cycle direction |
| bus_burst | output | 1 | Cycle belongs to a burst request |
| bus_addr | output | 32 | Address of the current cycle |
| bus_len | output | 3 | Bytes still pending |
| bus_wdata | output | 32 | Lane-steered write data |
| bus_ack | input | 1 | Transfer acknowledge for the current cycle |
| bus_port | input | 2 | Port width reported with the acknowledge |
| bus_rdata | input | 32 | Read data lanes |

## Verification
Every result is registered, so the timing is the same for all of them. `misalign` and the first bus cycle appear one clock after the request edge. Each follow-on cycle, or `done` together with the final `rd_data`, appears one clock after the acknowledging edge. The bench drives inputs on the falling edge and samples outputs at the next falling edge, which lands exactly one register stage after the stimulus. Each acknowledge is held for a single edge, so every cycle's address, length and lanes are checked before the acknowledge that retires it.

// File: rtl/opalign_pkg.sv
`timescale 1ns/1ps
package opalign_pkg;

  localparam int LANES  = 4;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_HALF  = 2'd1,
    SZ_WORD  = 2'd2,
    SZ_BURST = 2'd3
  } opsize_e;

  localparam logic [1:0] PW_32  = 2'd0;
  localparam logic [1:0] PW_8   = 2'd1;
  localparam logic [1:0] PW_16  = 2'd2;

  // lane 0 is the most significant byte
  function automatic logic [7:0] lane_of(input logic [31:0] w, input logic [1:0] l);
    return w[(3 - int'(l)) * BYTE_W +: BYTE_W];
  endfunction

  function automatic logic addr_ok(input logic [1:0] sz, input logic [1:0] lo);
    case (sz)
      SZ_BYTE: return 1'b1;
      SZ_HALF: return ~lo[0];
      default: return lo == 2'b00;
    endcase
  endfunction

  function automatic logic [1:0] first_off(input logic [1:0] sz, input logic [1:0] lo);
    case (sz)
      SZ_BYTE: return lo;
      SZ_HALF: return {lo[1], 1'b0};
      default: return 2'b00;
    endcase
  endfunction

  function automatic logic [2:0] op_len(input logic [1:0] sz);
    case (sz)
      SZ_BYTE: return 3'd1;
      SZ_HALF: return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

  // bytes a port of the given width absorbs in one cycle
  function automatic logic [2:0] step_len(input logic [1:0] pw, input logic [1:0] off,
                                          input logic [2:0] left);
    case (pw)
      PW_8:    return 3'd1;
      PW_16:   return (off[0] || left == 3'd1) ? 3'd1 : 3'd2;
      default: return left;
    endcase
  endfunction

  function automatic logic [1:0] rd_lane(input logic [1:0] pw, input logic [1:0] pos);
    case (pw)
      PW_8:    return 2'd0;
      PW_16:   return {1'b0, pos[0]};
      default: return pos;
    endcase
  endfunction

  function automatic logic in_win(input logic [1:0] pos, input logic [1:0] off,
                                  input logic [2:0] len);
    return ({1'b0, pos} >= {1'b0, off}) && ({1'b0, pos} < ({1'b0, off} + len));
  endfunction

  // right-justified operand to a lane image of the word
  function automatic logic [31:0] place_op(input logic [1:0] sz, input logic [1:0] lo,
                                           input logic [31:0] wd);
    case (sz)
      SZ_BYTE: return {24'h0, wd[7:0]} << (BYTE_W * (3 - int'(lo)));
      SZ_HALF: return lo[1] ? {16'h0, wd[15:0]} : {wd[15:0], 16'h0};
      default: return wd;
    endcase
  endfunction

  // write byte for lane l: natural lane, else 16-bit copy, else 8-bit copy on lane 0
  function automatic logic [7:0] steer_byte(input logic [31:0] img, input logic [1:0] l,
                                            input logic [1:0] off, input logic [2:0] len);
    logic [1:0] half_pos;
    half_pos = {off[1], l[0]};
    if (in_win(l, off, len))                        return lane_of(img, l);
    if (!l[1] && in_win(half_pos, off, len))        return lane_of(img, half_pos);
    if (l == 2'd0)                                  return lane_of(img, off);
    return 8'h00;
  endfunction

endpackage

// File: rtl/opalign_gate.sv
`timescale 1ns/1ps
module opalign_gate
  import opalign_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic       busy,
  input  logic [1:0] req_size,
  input  logic [1:0] addr_lo,
  output logic       accept,
  output logic       misalign_q
);

  logic legal_w;
  logic refuse_w;

  assign legal_w  = addr_ok(req_size, addr_lo);
  assign accept   = req_valid && !busy && legal_w;
  assign refuse_w = req_valid && !busy && !legal_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) misalign_q <= 1'b0;
    else        misalign_q <= refuse_w;
  end

  // a flagged request never starts a transfer on the following cycle
  assert_flag_no_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
    misalign_q |-> !$past(accept));

endmodule

// File: rtl/opalign_steer.sv
`timescale 1ns/1ps
module opalign_steer
  import opalign_pkg::*;
(
  input  logic [31:0] image,
  input  logic [1:0]  off,
  input  logic [2:0]  len,
  output logic [31:0] lanes
);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    localparam logic [1:0] LN = 2'(l);
    assign lanes[(LANES - 1 - l) * BYTE_W +: BYTE_W] = steer_byte(image, LN, off, len);
  end

  // lane 0 must always present the head of the pending bytes
  always_comb begin
    if (len != 3'd0)
      assert_lane0_head_R5: assert (lanes[31:24] == image[(3 - int'(off)) * BYTE_W +: BYTE_W]);
  end

endmodule

// File: rtl/opalign_seq.sv
`timescale 1ns/1ps
module opalign_seq
  import opalign_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic              req_we,
  input  logic [31:0]       req_wdata,
  input  logic              req_ctrl_int,
  input  logic              bus_ack,
  input  logic [1:0]        bus_port,
  input  logic [31:0]       bus_rdata,
  output logic              active,
  output logic              we_q,
  output logic              burst_q,
  output logic [ADDR_W-1:2] base_q,
  output logic [1:0]        off_q,
  output logic [2:0]        left_q,
  output logic [31:0]       image_q,
  output logic              done_q,
  output logic [31:0]       rd_data
);

  logic [1:0] size_q;
  logic [1:0] off0_q;
  logic       narrow_q;
  logic [1:0] pw_eff;
  logic [2:0] step_w;
  logic       beat_w;
  logic       last_w;

  assign pw_eff = narrow_q ? bus_port : PW_32;
  assign step_w = step_len(pw_eff, off_q, left_q);
  assign beat_w = active && bus_ack;
  assign last_w = beat_w && (step_w == left_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active   <= 1'b0;
      we_q     <= 1'b0;
      burst_q  <= 1'b0;
      base_q   <= '0;
      off_q    <= 2'd0;
      off0_q   <= 2'd0;
      left_q   <= 3'd0;
      size_q   <= 2'd0;
      narrow_q <= 1'b0;
      image_q  <= 32'h0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        active   <= 1'b1;
        we_q     <= req_we;
        burst_q  <= (req_size == SZ_BURST);
        base_q   <= req_addr[ADDR_W-1:2];
        off_q    <= first_off(req_size, req_addr[1:0]);
        off0_q   <= first_off(req_size, req_addr[1:0]);
        left_q   <= op_len(req_size);
        size_q   <= req_size;
        narrow_q <= req_ctrl_int;
        image_q  <= req_we ? place_op(req_size, req_addr[1:0], req_wdata) : 32'h0;
      end else if (beat_w) begin
        for (int p = 0; p < LANES; p++) begin
          if (!we_q && in_win(2'(p), off_q, step_w))
            image_q[(LANES - 1 - p) * BYTE_W +: BYTE_W] <= lane_of(bus_rdata, rd_lane(pw_eff, 2'(p)));
        end
        off_q  <= off_q + step_w[1:0];
        left_q <= left_q - step_w;
        if (last_w) begin
          active <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    case (size_q)
      SZ_BYTE: rd_data = {24'h0, lane_of(image_q, off0_q)};
      SZ_HALF: rd_data = {16'h0, lane_of(image_q, off0_q), lane_of(image_q, off0_q + 2'd1)};
      default: rd_data = image_q;
    endcase
  end

  assert_window_legal_R6: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (left_q != 3'd0) && (({1'b0, off_q} + left_q) <= 3'd4));

  assert_advance_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_w && !last_w) |=> active && (off_q != $past(off_q)) && (left_q < $past(left_q)));

  assert_ext_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_w && !narrow_q) |=> !active && done_q);

  assert_done_after_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> $past(beat_w) && !active);

endmodule

// File: rtl/bus_operand_aligner.sv
`timescale 1ns/1ps
module bus_operand_aligner
  import opalign_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic              req_we,
  input  logic [31:0]       req_wdata,
  input  logic              req_ctrl_int,
  output logic              busy,
  output logic              misalign,
  output logic              done,
  output logic [31:0]       rd_data,
  output logic              bus_req,
  output logic              bus_we,
  output logic              bus_burst,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [2:0]        bus_len,
  output logic [31:0]       bus_wdata,
  input  logic              bus_ack,
  input  logic [1:0]        bus_port,
  input  logic [31:0]       bus_rdata
);

  logic              accept;
  logic              active;
  logic              we_q;
  logic              burst_q;
  logic [ADDR_W-1:2] base_q;
  logic [1:0]        off_q;
  logic [2:0]        left_q;
  logic [31:0]       image_q;
  logic [31:0]       lanes_w;

  opalign_gate u_gate (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .busy       (active),
    .req_size   (req_size),
    .addr_lo    (req_addr[1:0]),
    .accept     (accept),
    .misalign_q (misalign)
  );

  opalign_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .accept       (accept),
    .req_addr     (req_addr),
    .req_size     (req_size),
    .req_we       (req_we),
    .req_wdata    (req_wdata),
    .req_ctrl_int (req_ctrl_int),
    .bus_ack      (bus_ack),
    .bus_port     (bus_port),
    .bus_rdata    (bus_rdata),
    .active       (active),
    .we_q         (we_q),
    .burst_q      (burst_q),
    .base_q       (base_q),
    .off_q        (off_q),
    .left_q       (left_q),
    .image_q      (image_q),
    .done_q       (done),
    .rd_data      (rd_data)
  );

  opalign_steer u_steer (
    .image (image_q),
    .off   (off_q),
    .len   (left_q),
    .lanes (lanes_w)
  );

  assign busy      = active;
  assign bus_req   = active;
  assign bus_we    = active && we_q;
  assign bus_burst = active && burst_q;
  assign bus_addr  = {base_q, off_q};
  assign bus_len   = active ? left_q : 3'd0;
  assign bus_wdata = (active && we_q) ? lanes_w : 32'h0;

  assert_misalign_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    misalign |-> !busy && !bus_req);

  assert_start_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_req) |-> (bus_len == 3'd1) || (bus_len == 3'd2) || (bus_len == 3'd4));

  assert_refuse_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && req_valid && !bus_ack) |=> $stable(bus_addr) && $stable(bus_len));

  assert_done_clean_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

// File: tb/sim_bus_operand_aligner.sv
`timescale 1ns/1ps
module sim_bus_operand_aligner;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic [1:0]  req_size = '0;
  logic        req_we = 1'b0;
  logic [31:0] req_wdata = '0;
  logic        req_ctrl_int = 1'b0;
  logic        busy, misalign, done, bus_req, bus_we, bus_burst;
  logic [31:0] rd_data, bus_addr, bus_wdata;
  logic [2:0]  bus_len;
  logic        bus_ack = 1'b0;
  logic [1:0]  bus_port = '0;
  logic [31:0] bus_rdata = '0;

  int n_chk = 0;
  int n_bad = 0;
  bit ended = 1'b0;

  always #2.5 clk = ~clk;

  bus_operand_aligner u0 (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  // request at a falling edge; returns at the next falling edge
  task automatic issue(input logic [31:0] a, input logic [1:0] sz, input logic we,
                       input logic [31:0] wd, input logic ci);
    req_valid = 1'b1; req_addr = a; req_size = sz; req_we = we;
    req_wdata = wd; req_ctrl_int = ci;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // check the live cycle, acknowledge it once, check its aftermath
  task automatic beat(input string tag, input logic [31:0] ea, input logic [2:0] el,
                      input logic [31:0] ew, input logic [31:0] wm, input logic [1:0] pw,
                      input logic [31:0] rd, input bit last);
    chk({tag, " bus_req"}, 32'(bus_req), 32'd1);
    chk({tag, " bus_addr"}, bus_addr, ea);
    chk({tag, " bus_len"}, 32'(bus_len), 32'(el));
    if (wm != 0) chk({tag, " lanes"}, bus_wdata & wm, ew & wm);
    bus_ack = 1'b1; bus_port = pw; bus_rdata = rd;
    @(negedge clk);
    bus_ack = 1'b0; bus_rdata = 32'hx;
    chk({tag, " done"}, 32'(done), 32'(last));
    chk({tag, " bus_req after"}, 32'(bus_req), 32'(!last));
  endtask

  task automatic t_reset();
    chk("R9 reset busy", 32'(busy), 0);
    chk("R9 reset done", 32'(done), 0);
    chk("R1 reset misalign", 32'(misalign), 0);
    chk("R3 reset bus_req", 32'(bus_req), 0);
  endtask

  task automatic t_word_write32();
    issue(32'h100, 2'd2, 1'b1, 32'hA1B2C3D4, 1'b1);
    chk("R3 busy", 32'(busy), 1);
    chk("R4 bus_we", 32'(bus_we), 1);
    beat("R4 word32", 32'h100, 3'd4, 32'hA1B2C3D4, 32'hFFFFFFFF, 2'b00, 32'h0, 1);
    chk("R9 busy low at done", 32'(busy), 0);
    @(negedge clk);
    chk("R9 done one cycle", 32'(done), 0);
  endtask

  task automatic t_word_read16();
    issue(32'h200, 2'd2, 1'b0, 32'h0, 1'b1);
    beat("R6 rd16 b1", 32'h200, 3'd4, 0, 0, 2'b10, 32'h1122EEEE, 0);
    beat("R6 rd16 b2", 32'h202, 3'd2, 0, 0, 2'b10, 32'h3344EEEE, 1);
    chk("R8 rd16 data", rd_data, 32'h11223344);
    @(negedge clk);
  endtask

  task automatic t_word_write8();
    issue(32'h300, 2'd2, 1'b1, 32'hDEADBEEF, 1'b1);
    beat("R5 wr8 b1", 32'h300, 3'd4, 32'hDE000000, 32'hFF000000, 2'b01, 0, 0);
    beat("R5 wr8 b2", 32'h301, 3'd3, 32'hAD000000, 32'hFF000000, 2'b01, 0, 0);
    beat("R5 wr8 b3", 32'h302, 3'd2, 32'hBEEFBEEF, 32'hFFFFFFFF, 2'b01, 0, 0);
    beat("R5 wr8 b4", 32'h303, 3'd1, 32'hEF0000EF, 32'hFF0000FF, 2'b01, 0, 1);
    @(negedge clk);
  endtask

  task automatic t_external();
    issue(32'h240, 2'd2, 1'b0, 32'h0, 1'b0);
    beat("R7 port ignored", 32'h240, 3'd4, 0, 0, 2'b10, 32'hCAFEF00D, 1);
    chk("R7 single beat data", rd_data, 32'hCAFEF00D);
    @(negedge clk);
  endtask

  task automatic t_half_and_byte();
    issue(32'h402, 2'd1, 1'b0, 32'h0, 1'b1);
    beat("R8 half rd32", 32'h402, 3'd2, 0, 0, 2'b00, 32'hEEEE5566, 1);
    chk("R8 half justified", rd_data, 32'h00005566);
    @(negedge clk);
    issue(32'h406, 2'd1, 1'b1, 32'hFFFF7788, 1'b1);
    beat("R5 half wr16", 32'h406, 3'd2, 32'h77887788, 32'hFFFFFFFF, 2'b10, 0, 1);
    @(negedge clk);
    issue(32'h503, 2'd0, 1'b1, 32'hFFFFFF55, 1'b1);
    beat("R4 byte wr8", 32'h503, 3'd1, 32'h55550055, 32'hFFFFFFFF, 2'b01, 0, 1);
    @(negedge clk);
    issue(32'h501, 2'd0, 1'b0, 32'h0, 1'b1);
    beat("R8 byte rd16", 32'h501, 3'd1, 0, 0, 2'b10, 32'hEEABEEEE, 1);
    chk("R8 byte rd16 data", rd_data, 32'h000000AB);
    @(negedge clk);
    issue(32'h502, 2'd0, 1'b0, 32'h0, 1'b1);
    beat("R8 byte rd8", 32'h502, 3'd1, 0, 0, 2'b01, 32'hCDEEEEEE, 1);
    chk("R8 byte rd8 data", rd_data, 32'h000000CD);
    @(negedge clk);
  endtask

  task automatic t_burst();
    issue(32'h600, 2'd3, 1'b1, 32'h01020304, 1'b1);
    chk("R2 burst flag", 32'(bus_burst), 1);
    beat("R2 burst beat", 32'h600, 3'd4, 32'h01020304, 32'hFFFFFFFF, 2'b00, 0, 1);
    @(negedge clk);
  endtask

  task automatic t_misalign(input logic [31:0] a, input logic [1:0] sz);
    issue(a, sz, 1'b0, 32'h0, 1'b1);
    chk("R1 misalign pulse", 32'(misalign), 1);
    chk("R1 no cycle", 32'(bus_req), 0);
    @(negedge clk);
    chk("R1 pulse ends", 32'(misalign), 0);
    chk("R1 still idle", 32'(busy), 0);
  endtask

  task automatic t_busy_refuse();
    issue(32'h700, 2'd2, 1'b0, 32'h0, 1'b1);
    issue(32'h7F0, 2'd2, 1'b0, 32'h0, 1'b1);
    chk("R10 addr kept", bus_addr, 32'h700);
    chk("R10 no misalign", 32'(misalign), 0);
    beat("R10 beat", 32'h700, 3'd4, 0, 0, 2'b00, 32'h0BADF00D, 1);
    @(negedge clk);
    chk("R10 no follow-on", 32'(bus_req), 0);
  endtask

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_word_write32();
    t_word_read16();
    t_word_write8();
    t_external();
    t_half_and_byte();
    t_burst();
    t_misalign(32'h101, 2'd1);
    t_misalign(32'h102, 2'd2);
    t_misalign(32'h203, 2'd3);
    t_busy_refuse();
    finish_run();
  end

endmodule